// File: doc/BRIEF.md
# Width-Selectable Compare Flag Generator

This block turns a compare operation into a condition word. It takes the two operands of an ALU operation, the result the ALU produced, the operation code and a width select. From these it computes zero, sign, overflow and carry at byte, halfword or word width. From those four it derives the unsigned "above" and the signed "greater" and "greater-or-equal" relations. The seven flags are packed into a fixed layout in a 32-bit word. A register write port stores that word in place of the arithmetic result.

A small branch evaluator sits beside the flag logic. It picks one bit of a condition word by a 5-bit index and compares that bit with an expected value. One selector code forces the branch to be taken. Both outputs are registered once, so each result appears one clock after its inputs are presented. The ALU and the branch sequencer that use these outputs live outside the block.

Top module: `cmp_flag_unit`

## Requirements
- R1: `widthSel` 0 selects 8-bit width (msb index 7), 1 selects 16-bit (msb 15), 2 selects 32-bit (msb 31), and 3 is treated as 32-bit.
- R2: The zero flag (bit 0) is 1 exactly when `aluRes`, masked to the selected width, is all zeros.
- R3: The sign flag (bit 3) equals `aluRes` at the msb index of the selected width.
- R4: The overflow flag (bit 2) is 1 when the sign flag differs from `opA`'s msb and `opA`'s msb differs from `opB`'s msb, both msbs taken at the selected width.
- R5: For `aluOp` 0x0 (add), the carry flag (bit 1) is bit W of `opA`+`opB`, where both operands are masked to width W. For `aluOp` 0x2 (subtract), it is bit W of the masked `opA`-`opB`, which is a borrow. For every other `aluOp` it is 0.
- R6: above (bit 6) = not carry and not zero. greater (bit 5) = (sign equals overflow) and not zero. greater-or-equal (bit 4) = sign equals overflow.
- R7: `flagWord` holds the flags at bits 6..0 in the order above, greater, greater-or-equal, sign, overflow, carry, zero. Bits 31..7 are always 0.
- R8: Both outputs are registered. They reflect the inputs present at the previous rising clock edge. While `rstN` is low they are 0.
- R9: `takeBranch` is 1 when `condSel` is 3. For `condSel` 0, 1 or 2 it is 1 exactly when `condWord[condBit]` equals `condExpect`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opA | input | 32 | First ALU operand |
| opB | input | 32 | Second ALU operand |
| aluRes | input | 32 | Result produced by the ALU |
| aluOp | input | 4 | ALU operation code (0x0 add, 0x2 subtract) |
| widthSel | input | 2 | Compare width: 0 byte, 1 halfword, 2/3 word |
| condWord | input | 32 | Condition register tested by the branch evaluator |
| condBit | input | 5 | Bit index into `condWord` |
| condExpect | input | 1 | Value the selected bit must equal |
| condSel | input | 2 | Branch selector; 3 means always taken |
| flagWord | output | 32 | Packed condition word |
| takeBranch | output | 1 | Branch decision |

## Verification
Every result of this block is due one rising edge after its inputs are applied: both the flag word and the branch decision pass through exactly one register. The driver applies a stimulus on a falling edge and queues the expected word and decision. The monitor wakes 1 ns after the following rising edge, pops exactly one queued item and compares it. Each comparison therefore lines up with the single register stage and never with a later or earlier cycle. Directed vectors cover each width with garbage in the upper bits, borrow and carry at the width boundary, non-arithmetic codes, width code 3 and the forced-branch selector. A long pseudo-random run then sweeps the rest.

// File: rtl/cmp_flag_pkg.sv
package cmp_flag_pkg;
  localparam int BASE_W    = 8;
  localparam int NUM_LANES = 3;
  localparam int DATA_W    = BASE_W << (NUM_LANES - 1);
  localparam int SEL_W     = 2;
  localparam int OP_W      = 4;
  localparam int FLAG_W    = 7;
  localparam int IDX_W     = $clog2(DATA_W);
  localparam logic [OP_W-1:0]  OP_ADD = 4'h0;
  localparam logic [OP_W-1:0]  OP_SUB = 4'h2;
  localparam logic [SEL_W-1:0] SEL_ALWAYS = 2'd3;

  // field order sets the packed bit layout: above at bit 6 ... zero at bit 0
  typedef struct packed {
    logic above;
    logic greater;
    logic greaterEq;
    logic sign;
    logic ovf;
    logic carry;
    logic zero;
  } cmp_flags_t;

  typedef struct packed {
    logic [NUM_LANES-1:0] laneSel;   // one-hot width lane
    logic                 useAddCo;
    logic                 useSubBo;
  } cmp_ctrl_t;
endpackage

// File: rtl/cmp_flag_ctrl.sv
module cmp_flag_ctrl
  import cmp_flag_pkg::*;
(
  input  logic [SEL_W-1:0] widthSel,
  input  logic [OP_W-1:0]  aluOp,
  output cmp_ctrl_t        ctrl
);
  always_comb begin
    ctrl = '0;
    if (int'(widthSel) < NUM_LANES)
      ctrl.laneSel[widthSel] = 1'b1;
    else
      ctrl.laneSel[NUM_LANES-1] = 1'b1;   // out-of-range code means widest
    ctrl.useAddCo = (aluOp == OP_ADD);
    ctrl.useSubBo = (aluOp == OP_SUB);
  end
endmodule

// File: rtl/cmp_flag_dp.sv
module cmp_flag_dp
  import cmp_flag_pkg::*;
(
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [DATA_W-1:0] aluRes,
  input  cmp_ctrl_t         ctrl,
  output cmp_flags_t        flags
);
  logic [NUM_LANES-1:0] laneZero, laneSign, laneAHi, laneBHi, laneCo, laneBo;

  for (genvar g = 0; g < NUM_LANES; g++) begin : gLane
    localparam int LW = BASE_W << g;
    logic [LW:0] sumW, diffW;
    always_comb begin
      sumW  = {1'b0, opA[LW-1:0]} + {1'b0, opB[LW-1:0]};
      diffW = {1'b0, opA[LW-1:0]} - {1'b0, opB[LW-1:0]};
    end
    assign laneZero[g] = ~|aluRes[LW-1:0];
    assign laneSign[g] = aluRes[LW-1];
    assign laneAHi[g]  = opA[LW-1];
    assign laneBHi[g]  = opB[LW-1];
    assign laneCo[g]   = sumW[LW];
    assign laneBo[g]   = diffW[LW];
  end

  logic zeroS, signS, aHi, bHi, ovfS, carryS;

  always_comb begin
    zeroS  = |(laneZero & ctrl.laneSel);
    signS  = |(laneSign & ctrl.laneSel);
    aHi    = |(laneAHi & ctrl.laneSel);
    bHi    = |(laneBHi & ctrl.laneSel);
    ovfS   = (signS != aHi) && (aHi != bHi);
    carryS = (ctrl.useAddCo && |(laneCo & ctrl.laneSel)) ||
             (ctrl.useSubBo && |(laneBo & ctrl.laneSel));
    flags.zero      = zeroS;
    flags.sign      = signS;
    flags.ovf       = ovfS;
    flags.carry     = carryS;
    flags.above     = !carryS && !zeroS;
    flags.greaterEq = (signS == ovfS);
    flags.greater   = (signS == ovfS) && !zeroS;
  end
endmodule

// File: rtl/cmp_branch_eval.sv
module cmp_branch_eval
  import cmp_flag_pkg::*;
(
  input  logic [DATA_W-1:0] condWord,
  input  logic [IDX_W-1:0]  condBit,
  input  logic              condExpect,
  input  logic [SEL_W-1:0]  condSel,
  output logic              take
);
  always_comb
    take = (condSel == SEL_ALWAYS) || (condWord[condBit] == condExpect);
endmodule

// File: rtl/cmp_flag_unit.sv
module cmp_flag_unit
  import cmp_flag_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [DATA_W-1:0] aluRes,
  input  logic [OP_W-1:0]   aluOp,
  input  logic [SEL_W-1:0]  widthSel,
  input  logic [DATA_W-1:0] condWord,
  input  logic [IDX_W-1:0]  condBit,
  input  logic              condExpect,
  input  logic [SEL_W-1:0]  condSel,
  output logic [DATA_W-1:0] flagWord,
  output logic              takeBranch
);
  cmp_ctrl_t  ctrl;
  cmp_flags_t flagsNext;
  logic       takeNext;

  cmp_flag_ctrl uCtrl (.widthSel(widthSel), .aluOp(aluOp), .ctrl(ctrl));
  cmp_flag_dp   uDp   (.opA(opA), .opB(opB), .aluRes(aluRes), .ctrl(ctrl),
                       .flags(flagsNext));
  cmp_branch_eval uBr (.condWord(condWord), .condBit(condBit),
                       .condExpect(condExpect), .condSel(condSel),
                       .take(takeNext));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flagWord   <= '0;
      takeBranch <= 1'b0;
    end else begin
      flagWord   <= {{(DATA_W-FLAG_W){1'b0}}, flagsNext};
      takeBranch <= takeNext;
    end
  end

  a_r7_upper_clear: assert property (@(posedge clk) disable iff (!rstN)
    flagWord[DATA_W-1:FLAG_W] == '0);
  a_r6_gt_implies_ge: assert property (@(posedge clk) disable iff (!rstN)
    flagWord[5] |-> flagWord[4]);
  a_r6_above_excludes: assert property (@(posedge clk) disable iff (!rstN)
    flagWord[6] |-> (!flagWord[1] && !flagWord[0]));
  a_r6_zero_not_gt: assert property (@(posedge clk) disable iff (!rstN)
    flagWord[0] |-> !flagWord[5]);
  a_r5_no_carry_other_op: assert property (@(posedge clk) disable iff (!rstN)
    (aluOp != OP_ADD && aluOp != OP_SUB) |=> !flagWord[1]);
  a_r9_forced_take: assert property (@(posedge clk) disable iff (!rstN)
    (condSel == SEL_ALWAYS) |=> takeBranch);
  a_r2_byte_zero: assert property (@(posedge clk) disable iff (!rstN)
    (widthSel == 2'd0 && aluRes[7:0] == 8'h00) |=> flagWord[0]);
endmodule

// File: tb/tb_cmp_flag_unit.sv
`timescale 1ns/1ps
module tb_cmp_flag_unit;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [31:0] opA = '0, opB = '0, aluRes = '0, condWord = '0;
  logic [3:0]  aluOp = '0;
  logic [1:0]  widthSel = '0, condSel = '0;
  logic [4:0]  condBit = '0;
  logic        condExpect = 1'b0;
  logic [31:0] flagWord;
  logic        takeBranch;

  always #4 clk = ~clk;

  cmp_flag_unit dut (.clk(clk), .rstN(rstN), .opA(opA), .opB(opB),
    .aluRes(aluRes), .aluOp(aluOp), .widthSel(widthSel), .condWord(condWord),
    .condBit(condBit), .condExpect(condExpect), .condSel(condSel),
    .flagWord(flagWord), .takeBranch(takeBranch));

  typedef struct {
    logic [31:0] flags;
    logic        take;
    string       tag;
  } exp_t;
  exp_t q[$];
  int testCount = 0;
  int failCount = 0;
  bit done = 0;

  function automatic logic [31:0] modelFlags(input logic [31:0] a, b, r,
      input logic [3:0] op, input logic [1:0] ws);
    int w;
    longint unsigned m, ra, rb;
    logic z, s, o, c, ah, bh;
    w  = (ws == 2'd0) ? 8 : (ws == 2'd1) ? 16 : 32;
    m  = (64'd1 << w) - 1;
    ra = longint'(a) & m;
    rb = longint'(b) & m;
    z  = ((longint'(r) & m) == 0);
    s  = r[w-1];
    ah = a[w-1];
    bh = b[w-1];
    o  = (s ^ ah) & (ah ^ bh);
    if (op == 4'h0)      c = ((ra + rb) >> w) & 1;
    else if (op == 4'h2) c = (ra < rb);
    else                 c = 1'b0;
    return {25'd0, ~c & ~z, (s == o) & ~z, s == o, s, o, c, z};
  endfunction

  task automatic drive(input logic [31:0] a, b, r, input logic [3:0] op,
      input logic [1:0] ws, input logic [31:0] cw, input logic [4:0] cb,
      input logic ce, input logic [1:0] cs, input string tag);
    exp_t e;
    @(negedge clk);
    opA = a; opB = b; aluRes = r; aluOp = op; widthSel = ws;
    condWord = cw; condBit = cb; condExpect = ce; condSel = cs;
    e.flags = modelFlags(a, b, r, op, ws);
    e.take  = (cs == 2'd3) ? 1'b1 : (cw[cb] == ce);
    e.tag   = tag;
    q.push_back(e);
  endtask

  // monitor: one register stage, so each item is due 1 ns after the next edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        testCount++;
        if (flagWord !== e.flags || takeBranch !== e.take) begin
          failCount++;
          $display("FAIL %s: flags=%h exp=%h take=%b exp=%b",
                   e.tag, flagWord, e.flags, takeBranch, e.take);
        end
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      failCount++;
      testCount++;
      $display("FAIL R8 watchdog expired: got=hung expected=finish");
      $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end

  initial begin
    logic [31:0] s;
    // R8 reset state
    drive(32'hFFFF_FFFF, 32'h1, 32'h0, 4'h0, 2'd0, 32'h0, 5'd0, 1'b0, 2'd3, "unused");
    void'(q.pop_back());
    @(posedge clk); #1;
    testCount++;
    if (flagWord !== 32'h0 || takeBranch !== 1'b0) begin
      failCount++;
      $display("FAIL R8 reset: flags=%h take=%b exp=0/0", flagWord, takeBranch);
    end
    @(negedge clk); rstN = 1'b1;

    // R1 R2 byte width ignores upper bits
    drive(32'h1234_5600, 32'h0, 32'hABCD_EF00, 4'h0, 2'd0, 32'h1, 5'd0, 1'b1, 2'd0, "R1 R2 byte zero");
    // R3 sign at bit 15 in halfword
    drive(32'h0, 32'h0, 32'h0000_8000, 4'h4, 2'd1, 32'h0, 5'd3, 1'b1, 2'd1, "R3 half sign");
    // R5 byte add carry out
    drive(32'h0000_00FF, 32'h0000_0001, 32'h0000_0100, 4'h0, 2'd0, 32'h0, 5'd0, 1'b0, 2'd2, "R5 byte add carry");
    // R5 subtract borrow at word width
    drive(32'h0000_0001, 32'h0000_0002, 32'hFFFF_FFFF, 4'h2, 2'd2, 32'h8000_0000, 5'd31, 1'b1, 2'd0, "R5 word borrow");
    // R5 other op never carries
    drive(32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0001, 4'h5, 2'd2, 32'h0, 5'd0, 1'b0, 2'd0, "R5 other op");
    // R4 overflow: signed min minus one in halfword
    drive(32'h0000_8000, 32'h0000_0001, 32'h0000_7FFF, 4'h2, 2'd1, 32'h0, 5'd0, 1'b1, 2'd0, "R4 half overflow");
    // R1 width code 3 behaves as word
    drive(32'h8000_0000, 32'h0, 32'h8000_0000, 4'h2, 2'd3, 32'h0, 5'd0, 1'b0, 2'd0, "R1 width3 word");
    // R6 greater on positive difference
    drive(32'd10, 32'd3, 32'd7, 4'h2, 2'd2, 32'h0, 5'd0, 1'b0, 2'd0, "R6 greater");
    // R6 equal: zero, ge but not greater
    drive(32'd5, 32'd5, 32'd0, 4'h2, 2'd2, 32'h0, 5'd0, 1'b0, 2'd0, "R6 equal");
    // R7 all-ones inputs layout
    drive(32'hFFFF_FFFF, 32'h0, 32'hFFFF_FFFF, 4'h0, 2'd2, 32'h0, 5'd0, 1'b0, 2'd0, "R7 layout");
    // R9 forced take and mismatch
    drive(32'h0, 32'h0, 32'h1, 4'h0, 2'd0, 32'h0, 5'd7, 1'b1, 2'd3, "R9 always taken");
    drive(32'h0, 32'h0, 32'h1, 4'h0, 2'd0, 32'h0000_0080, 5'd7, 1'b0, 2'd2, "R9 mismatch");
    drive(32'h0, 32'h0, 32'h1, 4'h0, 2'd0, 32'h0000_0080, 5'd7, 1'b1, 2'd1, "R9 match");

    s = 32'hC0FF_EE11;
    for (int i = 0; i < 400; i++) begin
      logic [31:0] a, b, r;
      s ^= s << 13; s ^= s >> 17; s ^= s << 5; a = s;
      s ^= s << 13; s ^= s >> 17; s ^= s << 5; b = s;
      s ^= s << 13; s ^= s >> 17; s ^= s << 5;
      r = (s[1:0] == 2'd0) ? a + b : (s[1:0] == 2'd1) ? a - b : (s[1:0] == 2'd2) ? s & 32'hFFFF_0000 : s;
      drive(a, b, r, s[7:4], s[9:8], a ^ b, s[14:10], s[15], s[17:16], "R6 R7 random");
    end
    while (q.size() > 0) @(negedge clk);
    repeat (2) @(negedge clk);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end
endmodule